// File: doc/BRIEF.md
# Serial Line Break Reset Detector

This block watches a serial receive line and asks for a system reset when the line is held low, with no high interval, for longer than a timeout given in microseconds. The receive input first passes through a flop synchronizer. A restartable prescaler turns system clock cycles into microseconds of continuous low time. When the count passes the clamped timeout, the block emits a one-cycle reset request. That happens once per low period, however long the low lasts.

The timeout input is clamped before use. Values below a lower limit switch the reset function off. Values above an upper limit are cut down to that limit.

The same block can also send a break to wake a host. A one-cycle request raises an override output. That output tells the transmit path to hold its line low for a fixed number of microseconds, and then lets it go. Frame reception and baud rate generation belong to other blocks.

Top module: `brk_reset_detect`

## Requirements
- R1: The receive line passes through two synchronizer flops, so low time is counted from the third rising clock edge after the line falls. DIV = CLK_HZ / 1_000_000 cycles make one microsecond.
- R2: For an effective timeout T > 0, `rst_req_o` is high in the cycle after rising edge 2 + (T+1)·DIV, counted from the first edge after the line falls. This happens only if the line is still low at the line input through edge (T+1)·DIV. A timeout between MIN_US and MAX_US is used unchanged.
- R3: Any sampled high on the line restarts the measurement. Two short lows separated by a high never add up to a request.
- R4: A timeout below MIN_US (default 1000) gives an effective timeout of zero. With a zero timeout no request is issued, however long the line stays low.
- R5: A timeout above MAX_US (default 255000) acts exactly as MAX_US.
- R6: `rst_req_o` is a single-cycle pulse. It occurs at most once per continuous low period, even when the low lasts well past the point where the internal counter saturates.
- R7: A `brk_go_i` pulse sampled while no break is running makes `tx_hold_low_o` high from the next cycle, for exactly BRK_US·DIV cycles. The output then drops to 0.
- R8: A `brk_go_i` pulse sampled while a break is running is ignored. The running break keeps its original length.
- R9: After reset both `rst_req_o` and `tx_hold_low_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, frequency CLK_HZ |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rx_i | input | 1 | Serial receive line, idle high |
| tmo_us_i | input | TMO_W | Break timeout in microseconds, before clamping |
| brk_go_i | input | 1 | One-cycle request to send a wake-up break |
| rst_req_o | output | 1 | One-cycle reset request |
| tx_hold_low_o | output | 1 | High while the transmit line must be forced low |

## Verification
A reset request is due in a fixed cycle. If the line falls just before rising edge 1, the request shows up after edge 2 + (T+1)·DIV: two synchronizer stages plus T+1 whole microseconds. The bench drives every input on the falling clock edge and counts falling edges from the fall of the line. It records the index of each request it sees and compares that index with the one computed from the clamped timeout, including the case where the release lands on the very last edge that still counts. A break starts on the edge after the request, and the bench checks both the first high sample and the exact number of high samples against BRK_US·DIV.

// File: rtl/brk_pkg.sv
package brk_pkg;

  // Width that holds the values 0 .. n-1 (at least one bit).
  function automatic int cnt_width(input int n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction

  // Limits a microsecond timeout: small values disable, large values saturate.
  function automatic logic [31:0] clamp_us(input logic [31:0] val,
                                           input int unsigned lo,
                                           input int unsigned hi);
    logic [31:0] res;
    if (val < lo)       res = '0;
    else if (val > hi)  res = hi;
    else                res = val;
    return res;
  endfunction

endpackage

// File: rtl/brk_rx_sync.sv
module brk_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain;

  // Each stage resets to the idle (high) line level.
  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) chain[0] <= 1'b1;
          else         chain[0] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) chain[s] <= 1'b1;
          else         chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/brk_us_tick.sv
module brk_us_tick #(
  parameter int DIV = 50
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic tick_o
);
  import brk_pkg::*;
  localparam int CW = cnt_width(DIV);
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt;

  generate
    if (DIV == 1) begin : g_pass
      // One cycle per microsecond: every enabled cycle is a tick.
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt <= '0;
        else         cnt <= '0;
      end
      assign tick_o = en_i && (cnt == LAST);
    end else begin : g_div
      // Restarts from zero whenever disabled, so the phase follows en_i.
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)           cnt <= '0;
        else if (!en_i)        cnt <= '0;
        else if (cnt == LAST)  cnt <= '0;
        else                   cnt <= cnt + 1'b1;
      end
      assign tick_o = en_i && (cnt == LAST);
    end
  endgenerate
endmodule

// File: rtl/brk_low_timer.sv
module brk_low_timer #(
  parameter int DIV    = 50,
  parameter int MAX_US = 255000
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              rx_s_i,
  input  logic [$clog2(MAX_US+2)-1:0]       thr_i,
  output logic                              hit_o
);
  localparam int LOW_W = $clog2(MAX_US + 2);
  localparam logic [LOW_W-1:0] LOW_MAX = LOW_W'(MAX_US + 1);

  logic             us_tick;
  logic [LOW_W-1:0] low_us;
  logic             fired;

  brk_us_tick #(.DIV(DIV)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (!rx_s_i),
    .tick_o (us_tick)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      low_us <= '0;
      fired  <= 1'b0;
      hit_o  <= 1'b0;
    end else begin
      hit_o <= 1'b0;
      if (rx_s_i) begin
        low_us <= '0;
        fired  <= 1'b0;
      end else if (us_tick) begin
        if (low_us != LOW_MAX) low_us <= low_us + 1'b1;
        // low_us becomes thr+1 here: the low time now exceeds the timeout
        if ((thr_i != '0) && !fired && (low_us >= thr_i)) begin
          hit_o <= 1'b1;
          fired <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/brk_tx_gen.sv
module brk_tx_gen #(
  parameter int DIV    = 50,
  parameter int BRK_US = 2000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic go_i,
  output logic hold_o
);
  import brk_pkg::*;
  localparam int BW = cnt_width(BRK_US);
  localparam logic [BW-1:0] LAST = BW'(BRK_US - 1);

  logic          us_tick;
  logic [BW-1:0] us_cnt;

  brk_us_tick #(.DIV(DIV)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (hold_o),
    .tick_o (us_tick)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_o <= 1'b0;
      us_cnt <= '0;
    end else if (!hold_o) begin
      if (go_i) begin
        hold_o <= 1'b1;
        us_cnt <= '0;
      end
    end else if (us_tick) begin
      if (us_cnt == LAST) hold_o <= 1'b0;
      else                us_cnt <= us_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/brk_reset_detect.sv
module brk_reset_detect #(
  parameter int CLK_HZ      = 50_000_000,
  parameter int TMO_W       = 32,
  parameter int MIN_US      = 1000,
  parameter int MAX_US      = 255000,
  parameter int BRK_US      = 2000,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rx_i,
  input  logic [TMO_W-1:0] tmo_us_i,
  input  logic             brk_go_i,
  output logic             rst_req_o,
  output logic             tx_hold_low_o
);
  import brk_pkg::*;

  localparam int DIV_CYC = (CLK_HZ / 1_000_000 < 1) ? 1 : CLK_HZ / 1_000_000;
  localparam int LOW_W   = $clog2(MAX_US + 2);

  logic             rx_s;
  logic [LOW_W-1:0] thr;

  // Clamped threshold, computed from the raw port value.
  assign thr = LOW_W'(clamp_us(32'(tmo_us_i), MIN_US, MAX_US));

  brk_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (rx_i),
    .q_o    (rx_s)
  );

  brk_low_timer #(.DIV(DIV_CYC), .MAX_US(MAX_US)) u_low (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rx_s_i (rx_s),
    .thr_i  (thr),
    .hit_o  (rst_req_o)
  );

  brk_tx_gen #(.DIV(DIV_CYC), .BRK_US(BRK_US)) u_tx (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .go_i   (brk_go_i),
    .hold_o (tx_hold_low_o)
  );
endmodule

// File: rtl/brk_reset_detect_sva.sv
module brk_reset_detect_sva #(
  parameter int TMO_W   = 32,
  parameter int MIN_US  = 1000,
  parameter int BRK_CYC = 100
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             rx_s,
  input logic [TMO_W-1:0] tmo_us_i,
  input logic             brk_go_i,
  input logic             rst_req_o,
  input logic             tx_hold_low_o
);
  // Length of the current run of tx_hold_low_o, counted by the checker.
  logic [31:0] run;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            run <= '0;
    else if (tx_hold_low_o) run <= run + 1;
    else                    run <= '0;
  end

  // R6: a request lasts one cycle
  a_r6_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |=> !rst_req_o);

  // R2: a request follows an edge with the synchronized line low
  a_r2_line_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |-> !$past(rx_s));

  // R4: no request unless the timeout was at least the lower limit
  a_r4_disabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |-> ($past(tmo_us_i) >= TMO_W'(MIN_US)));

  // R7: a break starts only on request
  a_r7_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tx_hold_low_o) |-> $past(brk_go_i));

  // R8: a break never runs past its length
  a_r8_max_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_hold_low_o |-> (run < BRK_CYC));

  // R7: a break ends only after its full length
  a_r7_full_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(tx_hold_low_o) |-> ($past(run) == BRK_CYC - 1));
endmodule

bind brk_reset_detect brk_reset_detect_sva #(
  .TMO_W   (TMO_W),
  .MIN_US  (MIN_US),
  .BRK_CYC (BRK_US * DIV_CYC)
) u_sva (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .rx_s          (rx_s),
  .tmo_us_i      (tmo_us_i),
  .brk_go_i      (brk_go_i),
  .rst_req_o     (rst_req_o),
  .tx_hold_low_o (tx_hold_low_o)
);

// File: tb/brk_reset_detect_test.sv
module brk_reset_detect_test;
  localparam int CLK_HZ = 2_000_000;
  localparam int MIN_US = 100;
  localparam int MAX_US = 900;
  localparam int BRK_US = 40;
  localparam int DIV    = CLK_HZ / 1_000_000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx = 1'b1;
  logic [31:0] tmo = '0;
  logic        brk_go = 1'b0;
  logic        rst_req;
  logic        tx_hold;

  int total = 0;
  int fails = 0;
  bit done  = 0;

  brk_reset_detect #(
    .CLK_HZ(CLK_HZ), .TMO_W(32), .MIN_US(MIN_US), .MAX_US(MAX_US),
    .BRK_US(BRK_US), .SYNC_STAGES(2)
  ) uut (
    .clk_i(clk), .rst_ni(rst_n), .rx_i(rx), .tmo_us_i(tmo),
    .brk_go_i(brk_go), .rst_req_o(rst_req), .tx_hold_low_o(tx_hold)
  );

  always #2 clk = ~clk;

  function automatic int eff_thr(input logic [31:0] v);
    if (v < MIN_US) return 0;
    if (v > MAX_US) return MAX_US;
    return int'(v);
  endfunction

  // Falling-edge index at which the request is due; 0 means none.
  function automatic int due_at(input logic [31:0] v, input int len);
    int t = eff_thr(v);
    int e = 2 + (t + 1) * DIV;
    if (t == 0 || e > len + 2) return 0;
    return e;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Holds rx low for len falling edges, then high; records requests.
  task automatic run_low(input logic [31:0] v, input int len, input string req);
    int seen = 0;
    int first = 0;
    int exp = due_at(v, len);
    @(negedge clk);
    tmo = v;
    rx  = 1'b0;
    for (int i = 1; i <= len + 6; i++) begin
      @(negedge clk);
      if (rst_req) begin
        seen++;
        if (first == 0) first = i;
      end
      if (i == len) rx = 1'b1;
    end
    chk(seen == ((exp != 0) ? 1 : 0), req, "pulse count", seen, (exp != 0) ? 1 : 0);
    chk(first == exp, req, "pulse cycle", first, exp);
  endtask

  // Requests a break, optionally a second request at edge index extra.
  task automatic run_brk(input int extra, input string req);
    int cnt = 0;
    int first = 0;
    @(negedge clk);
    brk_go = 1'b1;
    for (int i = 1; i <= BRK_US * DIV + 6; i++) begin
      @(negedge clk);
      if (tx_hold) begin
        cnt++;
        if (first == 0) first = i;
      end
      brk_go = (i == extra);
    end
    brk_go = 1'b0;
    chk(first == 1, req, "break start", first, 1);
    chk(cnt == BRK_US * DIV, req, "break length", cnt, BRK_US * DIV);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++;
      fails++;
      $display("FAIL watchdog all-R actual=hung expected=finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    // R9: outputs idle while and after reset
    chk(rst_req == 1'b0, "R9", "rst_req in reset", rst_req, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(rst_req == 1'b0, "R9", "rst_req after reset", rst_req, 0);
    chk(tx_hold == 1'b0, "R9", "tx_hold after reset", tx_hold, 0);

    // R1 R2: exact timing and the last counted edge
    run_low(32'd150, 400, "R2");
    run_low(32'd150, 302, "R1");
    run_low(32'd150, 301, "R1");
    run_low(32'd100, 300, "R2");
    // R3: two short lows with a high between them
    run_low(32'd150, 250, "R3");
    run_low(32'd150, 250, "R3");
    // R4: below lower limit disables
    run_low(32'd99, 2500, "R4");
    run_low(32'd0, 2000, "R4");
    // R5: above upper limit saturates
    run_low(32'd901, 2000, "R5");
    run_low(32'hFFFF_FFFF, 1900, "R5");
    // R6: one pulse for a very long low
    run_low(32'd900, 2600, "R6");
    run_low(32'd120, 2600, "R6");

    // R7 R8: break generation and ignored requests
    run_brk(0, "R7");
    run_brk(5, "R8");
    run_brk(BRK_US * DIV, "R8");

    // Random mix across all timeout ranges
    for (int n = 0; n < 20; n++) begin
      int kind = int'($urandom % 4);
      logic [31:0] v;
      int len = 50 + int'($urandom % 2000);
      if (kind == 0)      v = $urandom % MIN_US;
      else if (kind == 3) v = MAX_US + 1 + ($urandom % 5000);
      else                v = MIN_US + ($urandom % (MAX_US - MIN_US + 1));
      run_low(v, len, (kind == 0) ? "R4" : ((kind == 3) ? "R5" : "R2"));
    end

    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule